// File: doc/BRIEF.md
# Multi-Master Hardware Semaphore Bank

This block is a register-mapped bank of hardware semaphores. Several processors use it to coordinate access to shared resources. A requester claims a semaphore by writing its nonzero requester ID into that semaphore's register. It then reads the register back, and the claim has succeeded only if the owner field holds its own ID. The owner frees the semaphore by writing an all-zero word. A sideband master-ID input carries the identity of the master that issues a release. A release from any other master is dropped.

Each semaphore is a two-state machine with the states FREE and HELD:
- FREE goes to HELD on a claim (a write whose low nibble is nonzero), and the machine stores that nibble as the owner.
- FREE stays FREE on any other write.
- HELD goes to FREE on a release (an all-zero word while the sideband ID equals the owner).
- HELD stays HELD on every other write. This covers a contested claim, a repeated claim by the owner, a release from the wrong master, and a word whose ID field is zero but whose upper bits are not.

The bank also holds a global control register and a 16-bit interrupt status register. In the control register, bit 0 picks the protocol, and 0 means single-step claim. Status bits are raised by event pulses and cleared by writing ones to the clear-all register.

The bus is a simple synchronous register port. Writes take effect at the clock edge where the write enable is high. Read data is registered: it appears in the cycle after the read enable and holds until the next read.

Top module: `sema_bank`

## Requirements
- R1: After reset, every semaphore reads 0 (free), the control register (offset 0x00) reads 0, and the interrupt status (read at offset 0x90) reads 0.
- R2: Semaphore i (0..31) sits at byte offset 0x08 + 4*i. A write whose low 4 bits are nonzero claims a FREE semaphore, and bits 3:0 then read back as that ID with all upper bits 0.
- R3: A claim written to a semaphore HELD by a different ID is ignored, and the stored owner does not change.
- R4: A claim repeated by the current owner leaves the semaphore HELD by that owner.
- R5: Writing the all-zero word releases a HELD semaphore when the sideband master ID equals the owner, and the semaphore then reads 0.
- R6: An all-zero write from a master other than the owner is ignored.
- R7: A write whose bits 3:0 are zero but whose upper bits are nonzero neither claims nor releases.
- R8: Semaphores are independent. A write to one never changes another, including the first (0x08) and last (0x84) slots.
- R9: The control register at 0x00 stores bits 7:0 of the written word and reads them back zero-extended. Bit 0 = 0 selects the single-step claim protocol.
- R10: Each bit of the 16-bit interrupt status is set by a pulse on the matching event input. Writing a 1 to a bit at offset 0x90 clears that bit, and 0xFFFF clears all bits.
- R11: An event and a clear that hit the same status bit in the same cycle leave that bit set.
- R12: Reads of unmapped or misaligned offsets (for example 0x04, 0x88, 0x8C, 0x94, 0x0A) return 0, and writes to them change no state.
- R13: Read data appears in the cycle after the read enable is sampled, and it reflects every write completed at or before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr_en | input | 1 | Write strobe |
| bus_wr_data | input | 32 | Write data |
| bus_rd_en | input | 1 | Read strobe |
| bus_rd_data | output | 32 | Registered read data |
| bus_master_id | input | 4 | Sideband ID of the master issuing the access |
| irq_evt | input | 16 | Event pulses that set interrupt status bits |

## Verification
Every write, and every event pulse, lands in state at the edge where it is sampled. The bench therefore issues a read no earlier than the cycle after the write and expects the new value. Read data is registered, so each result is due exactly one cycle after the read enable is seen at an edge. The driver task pushes the expected word when it raises the read enable. The monitor pops and compares only on the falling edge that follows an edge where a read was sampled. This ties every comparison to that one-cycle latency, and it catches a missing or extra result when the queue runs dry or is left non-empty.

// File: rtl/sema_bank_pkg.sv
package sema_bank_pkg;

    parameter int NUM_SEM   = 32;
    parameter int ID_W      = 4;
    parameter int ADDR_W    = 8;
    parameter int DATA_W    = 32;
    parameter int CTRL_BITS = 8;
    parameter int IRQ_BITS  = 16;

    parameter int CTRL_OFS  = 'h00;
    parameter int SEM_BASE  = 'h08;
    parameter int IRQ_OFS   = 'h90;

    typedef enum logic [1:0] {
        RGN_NONE,
        RGN_CTRL,
        RGN_SEM,
        RGN_IRQ
    } region_e;

    typedef enum logic {
        S_FREE,
        S_HELD
    } sem_state_e;

endpackage

// File: rtl/sema_decode.sv
module sema_decode
    import sema_bank_pkg::*;
#(
    parameter int N_SEM = NUM_SEM,
    parameter int AW    = ADDR_W,
    localparam int IDX_W = (N_SEM > 1) ? $clog2(N_SEM) : 1
) (
    input  logic [AW-1:0]    addr,
    output region_e          region,
    output logic [IDX_W-1:0] sem_idx
);

    localparam int SEM_END = SEM_BASE + 4 * N_SEM;

    int unsigned a;
    logic        aligned;

    always_comb begin
        a       = int'(addr);
        aligned = (addr[1:0] == 2'b00);
        sem_idx = '0;
        region  = RGN_NONE;
        if (aligned) begin
            if (a == CTRL_OFS) begin
                region = RGN_CTRL;
            end else if (a == IRQ_OFS) begin
                region = RGN_IRQ;
            end else if (a >= SEM_BASE && a < SEM_END) begin
                region  = RGN_SEM;
                sem_idx = IDX_W'((a - SEM_BASE) >> 2);
            end
        end
    end

endmodule

// File: rtl/sema_cell.sv
module sema_cell
    import sema_bank_pkg::*;
#(
    parameter int IW = ID_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_hit,
    input  logic          wr_claim,
    input  logic          wr_zero,
    input  logic [IW-1:0] wr_id,
    input  logic [IW-1:0] req_id,
    output logic [IW-1:0] owner
);

    sem_state_e    state_q, state_d;
    logic [IW-1:0] owner_q, owner_d;

    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        unique case (state_q)
            S_FREE: begin
                if (wr_hit && wr_claim) begin
                    state_d = S_HELD;
                    owner_d = wr_id;
                end
            end
            S_HELD: begin
                if (wr_hit && wr_zero && (req_id == owner_q)) begin
                    state_d = S_FREE;
                    owner_d = '0;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_FREE;
            owner_q <= '0;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
        end
    end

    always_comb begin
        unique case (state_q)
            S_FREE: owner = '0;
            S_HELD: owner = owner_q;
        endcase
    end

endmodule

// File: rtl/sema_ctrl_irq.sv
module sema_ctrl_irq
    import sema_bank_pkg::*;
#(
    parameter int CB = CTRL_BITS,
    parameter int IB = IRQ_BITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_we,
    input  logic [CB-1:0] ctrl_wdata,
    input  logic          clr_we,
    input  logic [IB-1:0] clr_mask,
    input  logic [IB-1:0] evt,
    output logic [CB-1:0] ctrl_val,
    output logic [IB-1:0] irq_pend
);

    logic [IB-1:0] clr_eff;

    always_comb begin
        clr_eff = clr_we ? clr_mask : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_val <= '0;
            irq_pend <= '0;
        end else begin
            if (ctrl_we) begin
                ctrl_val <= ctrl_wdata;
            end
            irq_pend <= (irq_pend & ~clr_eff) | evt;
        end
    end

endmodule

// File: rtl/sema_bank.sv
module sema_bank
    import sema_bank_pkg::*;
#(
    parameter int N_SEM = NUM_SEM,
    parameter int IW    = ID_W,
    parameter int AW    = ADDR_W,
    parameter int DW    = DATA_W,
    parameter int CB    = CTRL_BITS,
    parameter int IB    = IRQ_BITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr_en,
    input  logic [DW-1:0] bus_wr_data,
    input  logic          bus_rd_en,
    output logic [DW-1:0] bus_rd_data,
    input  logic [IW-1:0] bus_master_id,
    input  logic [IB-1:0] irq_evt
);

    localparam int IDX_W = (N_SEM > 1) ? $clog2(N_SEM) : 1;

    region_e             region;
    logic [IDX_W-1:0]    sem_idx;
    logic [IW-1:0]       owner_arr [N_SEM];
    logic [N_SEM*IW-1:0] owner_flat;
    logic [CB-1:0]       ctrl_val;
    logic [IB-1:0]       irq_pend;
    logic                wr_claim;
    logic                wr_zero;
    logic [DW-1:0]       rd_next;

    sema_decode #(
        .N_SEM (N_SEM),
        .AW    (AW)
    ) u_dec (
        .addr    (bus_addr),
        .region  (region),
        .sem_idx (sem_idx)
    );

    always_comb begin
        wr_claim = (bus_wr_data[IW-1:0] != '0);
        wr_zero  = (bus_wr_data == '0);
    end

    for (genvar g = 0; g < N_SEM; g++) begin : g_cell
        logic hit;
        always_comb begin
            hit = bus_wr_en && (region == RGN_SEM) && (sem_idx == IDX_W'(g));
        end
        sema_cell #(.IW(IW)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_hit   (hit),
            .wr_claim (wr_claim),
            .wr_zero  (wr_zero),
            .wr_id    (bus_wr_data[IW-1:0]),
            .req_id   (bus_master_id),
            .owner    (owner_arr[g])
        );
        assign owner_flat[g*IW +: IW] = owner_arr[g];
    end

    sema_ctrl_irq #(
        .CB (CB),
        .IB (IB)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_we    (bus_wr_en && (region == RGN_CTRL)),
        .ctrl_wdata (bus_wr_data[CB-1:0]),
        .clr_we     (bus_wr_en && (region == RGN_IRQ)),
        .clr_mask   (bus_wr_data[IB-1:0]),
        .evt        (irq_evt),
        .ctrl_val   (ctrl_val),
        .irq_pend   (irq_pend)
    );

    always_comb begin
        rd_next = '0;
        unique case (region)
            RGN_NONE: rd_next = '0;
            RGN_CTRL: rd_next = DW'(ctrl_val);
            RGN_SEM:  rd_next = DW'(owner_arr[sem_idx]);
            RGN_IRQ:  rd_next = DW'(irq_pend);
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rd_data <= '0;
        end else if (bus_rd_en) begin
            bus_rd_data <= rd_next;
        end
    end

endmodule

// File: rtl/sema_bank_chk.sv
module sema_bank_chk
    import sema_bank_pkg::*;
#(
    parameter int N_SEM = NUM_SEM,
    parameter int IW    = ID_W,
    parameter int AW    = ADDR_W,
    parameter int DW    = DATA_W,
    parameter int CB    = CTRL_BITS,
    parameter int IB    = IRQ_BITS
) (
    input logic                clk,
    input logic                rst_n,
    input logic [AW-1:0]       bus_addr,
    input logic                bus_wr_en,
    input logic [DW-1:0]       bus_wr_data,
    input logic                bus_rd_en,
    input logic [DW-1:0]       bus_rd_data,
    input logic [IW-1:0]       bus_master_id,
    input logic [IB-1:0]       irq_evt,
    input logic [N_SEM*IW-1:0] owner_flat,
    input logic [CB-1:0]       ctrl_val,
    input logic [IB-1:0]       irq_pend
);

    localparam int IDX_W   = (N_SEM > 1) ? $clog2(N_SEM) : 1;
    localparam int SEM_END = SEM_BASE + 4 * N_SEM;

    logic             sem_sel;
    logic             mapped;
    logic [IDX_W-1:0] cidx;
    logic [IDX_W-1:0] idx_d;
    logic [IW-1:0]    cur_owner;

    always_comb begin
        sem_sel = (bus_addr[1:0] == 2'b00) && (int'(bus_addr) >= SEM_BASE)
                  && (int'(bus_addr) < SEM_END);
        mapped  = sem_sel || (int'(bus_addr) == CTRL_OFS) || (int'(bus_addr) == IRQ_OFS);
        cidx    = IDX_W'((int'(bus_addr) - SEM_BASE) >> 2);
        cur_owner = owner_flat[cidx*IW +: IW];
    end

    always_ff @(posedge clk) begin
        idx_d <= cidx;
    end

    // R2: a claim on a free slot installs the written ID
    assert_claim_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && sem_sel && cur_owner == '0 && bus_wr_data[IW-1:0] != '0)
        |=> owner_flat[idx_d*IW +: IW] == $past(bus_wr_data[IW-1:0]));

    // R3: contested claim leaves every owner unchanged
    assert_contest_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && sem_sel && cur_owner != '0 && bus_wr_data[IW-1:0] != '0
         && bus_wr_data[IW-1:0] != cur_owner)
        |=> owner_flat == $past(owner_flat));

    // R6: release from a non-owner is dropped
    assert_foreign_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && sem_sel && bus_wr_data == '0 && bus_master_id != cur_owner)
        |=> owner_flat == $past(owner_flat));

    // R5: owner release frees the slot
    assert_owner_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && sem_sel && bus_wr_data == '0 && bus_master_id == cur_owner)
        |=> owner_flat[idx_d*IW +: IW] == '0);

    // R9: control write is stored
    assert_ctrl_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && int'(bus_addr) == CTRL_OFS)
        |=> ctrl_val == $past(bus_wr_data[CB-1:0]));

    // R10: full clear with no events empties status
    assert_clear_all_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && int'(bus_addr) == IRQ_OFS && bus_wr_data[IB-1:0] == '1
         && irq_evt == '0)
        |=> irq_pend == '0);

    // R12: unmapped reads return zero
    assert_unmapped_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && !mapped) |=> bus_rd_data == '0);

    // R12: unmapped writes touch no semaphore
    assert_unmapped_nowrite_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && !mapped) |=> owner_flat == $past(owner_flat));

endmodule

bind sema_bank sema_bank_chk #(
    .N_SEM (N_SEM),
    .IW    (IW),
    .AW    (AW),
    .DW    (DW),
    .CB    (CB),
    .IB    (IB)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr      (bus_addr),
    .bus_wr_en     (bus_wr_en),
    .bus_wr_data   (bus_wr_data),
    .bus_rd_en     (bus_rd_en),
    .bus_rd_data   (bus_rd_data),
    .bus_master_id (bus_master_id),
    .irq_evt       (irq_evt),
    .owner_flat    (owner_flat),
    .ctrl_val      (ctrl_val),
    .irq_pend      (irq_pend)
);

// File: tb/test_sema_bank.sv
module test_sema_bank;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  bus_addr;
    logic        bus_wr_en;
    logic [31:0] bus_wr_data;
    logic        bus_rd_en;
    logic [31:0] bus_rd_data;
    logic [3:0]  bus_master_id;
    logic [15:0] irq_evt;

    int total = 0;
    int bad   = 0;
    logic rd_seen = 1'b0;
    logic finished = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    sema_bank i_sema_bank (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_addr      (bus_addr),
        .bus_wr_en     (bus_wr_en),
        .bus_wr_data   (bus_wr_data),
        .bus_rd_en     (bus_rd_en),
        .bus_rd_data   (bus_rd_data),
        .bus_master_id (bus_master_id),
        .irq_evt       (irq_evt)
    );

    function automatic logic [7:0] sem_ofs(input int i);
        return 8'(8 + 4 * i);
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d,
                      input logic [3:0] mid, input logic [15:0] evt);
        @(negedge clk);
        bus_addr      = a;
        bus_wr_data   = d;
        bus_master_id = mid;
        irq_evt       = evt;
        bus_wr_en     = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
        irq_evt   = '0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        bus_addr  = a;
        bus_rd_en = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        bus_rd_en = 1'b0;
    endtask

    always @(posedge clk) rd_seen <= bus_rd_en;

    // monitor: result due one cycle after the sampled read strobe
    always @(negedge clk) begin
        if (rd_seen && !finished) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL unexpected read result: actual=%08h expected=none", bus_rd_data);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rd_data !== e) begin
                    bad++;
                    $display("FAIL %s: actual=%08h expected=%08h", t, bus_rd_data, e);
                end
            end
        end
    end

    task automatic report();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        report();
    end

    initial begin
        rst_n = 1'b0;
        bus_addr = '0; bus_wr_en = 1'b0; bus_wr_data = '0;
        bus_rd_en = 1'b0; bus_master_id = '0; irq_evt = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int i = 0; i < 32; i++) rd(sem_ofs(i), 32'h0, "R1 sem reset");
        rd(8'h00, 32'h0, "R1 ctrl reset");
        rd(8'h90, 32'h0, "R1 irq reset");

        // R2 claim, upper bits of write ignored for ID; R13 read right after write
        wr(sem_ofs(3), 32'hABCD_0001, 4'h1, '0);
        rd(sem_ofs(3), 32'h1, "R2 claim id1");
        // R3 contested claim
        wr(sem_ofs(3), 32'h2, 4'h2, '0);
        rd(sem_ofs(3), 32'h1, "R3 contested");
        // R4 repeated claim by owner
        wr(sem_ofs(3), 32'h1, 4'h1, '0);
        rd(sem_ofs(3), 32'h1, "R4 reclaim");
        // R6 foreign release
        wr(sem_ofs(3), 32'h0, 4'h2, '0);
        rd(sem_ofs(3), 32'h1, "R6 foreign release");
        // R7 zero ID, nonzero upper bits
        wr(sem_ofs(3), 32'h0000_0100, 4'h1, '0);
        rd(sem_ofs(3), 32'h1, "R7 zero-id word");
        // R5 owner release
        wr(sem_ofs(3), 32'h0, 4'h1, '0);
        rd(sem_ofs(3), 32'h0, "R5 release");
        // R5 released slot can be claimed by another master
        wr(sem_ofs(3), 32'h7, 4'h7, '0);
        rd(sem_ofs(3), 32'h7, "R5 reclaim after release");

        // R8 independence at the ends
        wr(sem_ofs(0), 32'hC, 4'hC, '0);
        wr(sem_ofs(31), 32'hF, 4'hF, '0);
        rd(8'h08, 32'hC, "R8 first slot");
        rd(8'h84, 32'hF, "R8 last slot");
        rd(sem_ofs(1), 32'h0, "R8 neighbour");
        rd(sem_ofs(30), 32'h0, "R8 neighbour");
        rd(sem_ofs(3), 32'h7, "R8 other held");

        // R9 control storage
        wr(8'h00, 32'hFFFF_FFFF, 4'h1, '0);
        rd(8'h00, 32'h0000_00FF, "R9 ctrl store");
        wr(8'h00, 32'h0000_0000, 4'h1, '0);
        rd(8'h00, 32'h0, "R9 protocol bit clear");

        // R10 irq set and clear
        wr(8'h04, 32'h0, 4'h1, 16'h00A5);
        rd(8'h90, 32'h0000_00A5, "R10 events set");
        wr(8'h90, 32'h0000_0005, 4'h1, '0);
        rd(8'h90, 32'h0000_00A0, "R10 partial clear");
        wr(8'h90, 32'h0000_FFFF, 4'h1, '0);
        rd(8'h90, 32'h0, "R10 clear all");
        // R11 same-cycle event and clear
        wr(8'h90, 32'h0000_FFFF, 4'h1, 16'h0002);
        rd(8'h90, 32'h0000_0002, "R11 event beats clear");
        wr(8'h90, 32'h0000_FFFF, 4'h1, '0);

        // R12 unmapped accesses
        wr(8'h04, 32'h3, 4'h3, '0);
        wr(8'h88, 32'h3, 4'h3, '0);
        wr(8'h8C, 32'h3, 4'h3, '0);
        wr(8'h94, 32'h3, 4'h3, '0);
        wr(8'h0A, 32'h0, 4'hC, '0);
        wr(8'h09, 32'h3, 4'h3, '0);
        rd(8'h04, 32'h0, "R12 read 0x04");
        rd(8'h88, 32'h0, "R12 read 0x88");
        rd(8'h8C, 32'h0, "R12 read 0x8C");
        rd(8'h94, 32'h0, "R12 read 0x94");
        rd(8'h0A, 32'h0, "R12 read misaligned");
        rd(8'h08, 32'hC, "R12 slot0 untouched");
        rd(8'h00, 32'h0, "R12 ctrl untouched");
        rd(8'h90, 32'h0, "R12 irq untouched");

        repeat (3) @(negedge clk);
        total++;
        if (exp_q.size() != 0) begin
            bad++;
            $display("FAIL R13 missing results: actual=%0d expected=0", exp_q.size());
        end
        report();
    end

endmodule